// File: doc/BRIEF.md
# Lane Execution-Mask Stack

This block keeps track of which lanes of a wide parallel vector unit are enabled while a program runs through nested if/else/endif regions. A scalar sequencer issues one command per cycle. A launch command loads the lanes that start live in a new wavefront. An IF command carries a per-lane condition, one bit per lane, which each lane produces from its own compare. ELSE and ENDIF carry no data. The block drives the current execution mask to the vector datapath.

Each nesting level stores one saved mask. An IF saves the lanes that were live but failed the condition. An ELSE swaps those lanes in and keeps the lanes that ran the IF body. An ENDIF merges the saved lanes back into the mask. An idle flag shows when no lane is enabled, so the sequencer can branch over a dead body. In pixel mode, an outermost ENDIF that leaves no live lane raises a null-target export strobe and, one cycle later, a terminate request for the wavefront. The saved masks are held in a fixed-depth register stack. Pushing past its depth, or closing a region that is not open, sets a sticky error flag and changes no state.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, exec_mask is all ones, the stack holds no entry, and exec_idle, export_null, terminate, overflow_err and underflow_err are all 0.
- R2: An accepted IF with a free stack slot sets exec_mask to the old mask AND cond_mask on the next clock edge. It also pushes the old mask XOR the new mask, which is the set of live lanes that failed the condition.
- R3: An accepted ELSE with a non-empty stack sets exec_mask to the top stack entry. It also overwrites that entry with the exec_mask held before the ELSE.
- R4: An accepted ENDIF with a non-empty stack sets exec_mask to exec_mask OR the top entry, then pops that entry.
- R5: ELSE and ENDIF always act on the entry pushed by the most recent unmatched IF (last in, first out), for up to DEPTH nested levels.
- R6: exec_idle is 1 exactly when the registered exec_mask is all zeros, so it reports a dead body in the cycle after an IF or ELSE that empties the mask.
- R7: An ENDIF accepted while pixel_mode is 1 that leaves the stack empty and exec_mask all zeros pulses export_null high for one cycle, starting at the next edge. terminate then pulses high for one cycle at the edge after that. No strobe appears when pixel_mode is 0 or when stack entries remain.
- R8: An IF accepted while DEPTH entries are held sets overflow_err, which stays set until reset. exec_mask and the stack are left unchanged.
- R9: An ELSE or ENDIF accepted while the stack is empty sets underflow_err, which stays set until reset. exec_mask is left unchanged.
- R10: At most one command is taken per cycle, in the priority launch > IF > ELSE > ENDIF. Lower-priority commands asserted in the same cycle are ignored.
- R11: An accepted launch loads exec_mask from launch_mask and empties the stack on the next edge. The error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixel_mode | input | 1 | Enables the kill sequence on an empty outermost exit |
| launch | input | 1 | Start a wavefront with launch_mask |
| launch_mask | input | LANES | Initial live lanes |
| op_if | input | 1 | Open a conditional region |
| cond_mask | input | LANES | Per-lane condition for op_if |
| op_else | input | 1 | Switch to the other branch |
| op_endif | input | 1 | Close the innermost region |
| exec_mask | output | LANES | Current per-lane enable |
| exec_idle | output | 1 | No lane enabled |
| export_null | output | 1 | Null-target export strobe |
| terminate | output | 1 | Wavefront terminate request |
| overflow_err | output | 1 | Sticky: IF with full stack |
| underflow_err | output | 1 | Sticky: ELSE/ENDIF with empty stack |

## Verification
The assertions check every cycle that an IF never enables a new lane, that an ENDIF never drops a lane, and that rejected pushes and pops keep the mask stable. They also check that the error flags stay set, that terminate always follows export_null, and that the stack level stays within its bound. Only the bench scenarios can show that the lanes restored by ELSE and ENDIF are the right ones through several nested levels. The same holds for the exact kill conditions in pixel mode and for the command priority, which the bench compares against its queue-based model on every clock.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LAUNCH,
        CMD_IF,
        CMD_ELSE,
        CMD_ENDIF
    } lms_cmd_e;
endpackage

// File: rtl/lms_cmd_sel.sv
module lms_cmd_sel
    import lms_pkg::*;
(
    input  logic     launch,
    input  logic     op_if,
    input  logic     op_else,
    input  logic     op_endif,
    output lms_cmd_e cmd
);
    // Fixed priority: one command per cycle (R10)
    always_comb begin
        if (launch)        cmd = CMD_LAUNCH;
        else if (op_if)    cmd = CMD_IF;
        else if (op_else)  cmd = CMD_ELSE;
        else if (op_endif) cmd = CMD_ENDIF;
        else               cmd = CMD_NONE;
    end
endmodule

// File: rtl/lms_mask_stack.sv
module lms_mask_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic             replace,
    input  logic [LANES-1:0] wr_data,
    output logic [LANES-1:0] top_data,
    output logic             full,
    output logic             empty,
    output logic             single
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][LANES-1:0] ent;
        logic [LVL_W-1:0]            level;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [LVL_W-1:0] top_lvl;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] push_idx;

    assign top_lvl  = stk_q.level - 1'b1;
    assign top_idx  = top_lvl[IDX_W-1:0];
    assign push_idx = stk_q.level[IDX_W-1:0];
    assign empty    = (stk_q.level == '0);
    assign full     = (stk_q.level == LVL_W'(DEPTH));
    assign single   = (stk_q.level == LVL_W'(1));
    assign top_data = empty ? '0 : stk_q.ent[top_idx];

    always_comb begin
        stk_d = stk_q;
        if (clear) begin
            stk_d.level = '0;
        end else if (push && !full) begin
            stk_d.ent[push_idx] = wr_data;
            stk_d.level         = stk_q.level + 1'b1;
        end else if (replace && !empty) begin
            stk_d.ent[top_idx] = wr_data;
        end else if (pop && !empty) begin
            stk_d.level = top_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q.level <= '0;
            stk_q.ent   <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.level <= LVL_W'(DEPTH));
    p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clear) |=> (stk_q.level == $past(stk_q.level) + 1'b1));
    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !clear && !push && !replace) |=> (stk_q.level == $past(stk_q.level) - 1'b1));
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
    import lms_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pixel_mode,
    input  logic             launch,
    input  logic [LANES-1:0] launch_mask,
    input  logic             op_if,
    input  logic [LANES-1:0] cond_mask,
    input  logic             op_else,
    input  logic             op_endif,
    output logic [LANES-1:0] exec_mask,
    output logic             exec_idle,
    output logic             export_null,
    output logic             terminate,
    output logic             overflow_err,
    output logic             underflow_err
);
    typedef struct packed {
        logic [LANES-1:0] exec;
        logic             ovf;
        logic             udf;
        logic             exp;
        logic             term;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    lms_cmd_e         cmd;
    logic [LANES-1:0] top_data, wr_data, taken;
    logic             full, empty, single;
    logic             st_clear, st_push, st_pop, st_replace;

    lms_cmd_sel i_sel (
        .launch   (launch),
        .op_if    (op_if),
        .op_else  (op_else),
        .op_endif (op_endif),
        .cmd      (cmd)
    );

    lms_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (st_clear),
        .push     (st_push),
        .pop      (st_pop),
        .replace  (st_replace),
        .wr_data  (wr_data),
        .top_data (top_data),
        .full     (full),
        .empty    (empty),
        .single   (single)
    );

    assign taken = ctl_q.exec & cond_mask;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.exp  = 1'b0;
        ctl_d.term = ctl_q.exp;
        st_clear   = 1'b0;
        st_push    = 1'b0;
        st_pop     = 1'b0;
        st_replace = 1'b0;
        wr_data    = '0;
        unique case (cmd)
            CMD_LAUNCH: begin
                ctl_d.exec = launch_mask;
                st_clear   = 1'b1;
            end
            CMD_IF: begin
                if (full) begin
                    ctl_d.ovf = 1'b1;
                end else begin
                    ctl_d.exec = taken;
                    wr_data    = ctl_q.exec ^ taken;
                    st_push    = 1'b1;
                end
            end
            CMD_ELSE: begin
                if (empty) begin
                    ctl_d.udf = 1'b1;
                end else begin
                    ctl_d.exec = top_data;
                    wr_data    = ctl_q.exec;
                    st_replace = 1'b1;
                end
            end
            CMD_ENDIF: begin
                if (empty) begin
                    ctl_d.udf = 1'b1;
                end else begin
                    ctl_d.exec = ctl_q.exec | top_data;
                    st_pop     = 1'b1;
                    ctl_d.exp  = pixel_mode && single && (ctl_d.exec == '0);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.exec <= '1;
            ctl_q.ovf  <= 1'b0;
            ctl_q.udf  <= 1'b0;
            ctl_q.exp  <= 1'b0;
            ctl_q.term <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign exec_mask     = ctl_q.exec;
    assign exec_idle     = (ctl_q.exec == '0);
    assign export_null   = ctl_q.exp;
    assign terminate     = ctl_q.term;
    assign overflow_err  = ctl_q.ovf;
    assign underflow_err = ctl_q.udf;

    p_if_narrows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IF && !full) |=> ((exec_mask & ~$past(exec_mask)) == '0));
    p_endif_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ENDIF && !empty) |=> (($past(exec_mask) & ~exec_mask) == '0));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IF && full) |=> ($stable(exec_mask) && overflow_err));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_ELSE || cmd == CMD_ENDIF) && empty) |=> ($stable(exec_mask) && underflow_err));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);
    p_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    p_kill_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        export_null |=> (terminate && !export_null));
    p_kill_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        export_null |-> exec_idle);
endmodule

// File: tb/test_lane_mask_stack.sv
module test_lane_mask_stack;
    localparam int LANES = 64;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pixel_mode = 1'b0;
    logic             launch = 1'b0;
    logic [LANES-1:0] launch_mask = '0;
    logic             op_if = 1'b0;
    logic [LANES-1:0] cond_mask = '0;
    logic             op_else = 1'b0;
    logic             op_endif = 1'b0;
    logic [LANES-1:0] exec_mask;
    logic             exec_idle, export_null, terminate, overflow_err, underflow_err;

    always #5 clk = ~clk;

    lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_lane_mask_stack (
        .clk(clk), .rst_n(rst_n), .pixel_mode(pixel_mode),
        .launch(launch), .launch_mask(launch_mask),
        .op_if(op_if), .cond_mask(cond_mask),
        .op_else(op_else), .op_endif(op_endif),
        .exec_mask(exec_mask), .exec_idle(exec_idle),
        .export_null(export_null), .terminate(terminate),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    // reference model
    logic [LANES-1:0] m_stk[$];
    logic [LANES-1:0] m_exec = '1;
    logic             m_ovf = 0, m_udf = 0, m_exp = 0, m_term = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "exec_mask", exec_mask, m_exec);
        chk(tag, "exec_idle", LANES'(exec_idle), LANES'(m_exec == '0));
        chk(tag, "export_null", LANES'(export_null), LANES'(m_exp));
        chk(tag, "terminate", LANES'(terminate), LANES'(m_term));
        chk(tag, "overflow_err", LANES'(overflow_err), LANES'(m_ovf));
        chk(tag, "underflow_err", LANES'(underflow_err), LANES'(m_udf));
    endtask

    task automatic step(input logic l, input logic [LANES-1:0] lm, input logic i,
                        input logic [LANES-1:0] c, input logic e, input logic n,
                        input logic px, input string tag);
        logic kill;
        logic [LANES-1:0] nm, t;
        @(negedge clk);
        launch = l; launch_mask = lm; op_if = i; cond_mask = c;
        op_else = e; op_endif = n; pixel_mode = px;
        @(posedge clk);
        kill = 0;
        if (l) begin
            m_exec = lm; m_stk.delete();
        end else if (i) begin
            if (m_stk.size() == DEPTH) m_ovf = 1;
            else begin nm = m_exec & c; m_stk.push_back(m_exec ^ nm); m_exec = nm; end
        end else if (e) begin
            if (m_stk.size() == 0) m_udf = 1;
            else begin t = m_stk[$]; m_stk[$] = m_exec; m_exec = t; end
        end else if (n) begin
            if (m_stk.size() == 0) m_udf = 1;
            else begin
                m_exec = m_exec | m_stk[$];
                void'(m_stk.pop_back());
                kill = px && (m_stk.size() == 0) && (m_exec == '0);
            end
        end
        m_term = m_exp;
        m_exp = kill;
        #1;
        compare(tag);
    endtask

    task automatic idle(input int k, input string tag);
        for (int j = 0; j < k; j++) step(0, '0, 0, '0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: single IF, then R4 restore
        step(0, '0, 1, 64'h00FF_00FF_F0F0_1234, 0, 0, 0, "R2 if");
        step(0, '0, 0, '0, 0, 1, 0, "R4 endif");
        // R3: if/else/endif
        step(0, '0, 1, 64'hAAAA_5555_0000_FFFF, 0, 0, 0, "R2 if");
        step(0, '0, 0, '0, 1, 0, 0, "R3 else");
        step(0, '0, 0, '0, 0, 1, 0, "R4 endif");
        // R5: nested LIFO with elses at each level
        step(0, '0, 1, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, "R5 if1");
        step(0, '0, 1, 64'hFF00_FF00_FF00_FF00, 0, 0, 0, "R5 if2");
        step(0, '0, 1, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 0, "R5 if3");
        step(0, '0, 0, '0, 1, 0, 0, "R5 else3");
        step(0, '0, 0, '0, 0, 1, 0, "R5 endif3");
        step(0, '0, 0, '0, 1, 0, 0, "R5 else2");
        step(0, '0, 0, '0, 0, 1, 0, "R5 endif2");
        step(0, '0, 0, '0, 1, 0, 0, "R5 else1");
        step(0, '0, 0, '0, 0, 1, 0, "R5 endif1");
        // R6: IF that kills all lanes, ELSE revives
        step(0, '0, 1, '0, 0, 0, 0, "R6 idle after if");
        step(0, '0, 0, '0, 1, 0, 0, "R6 else revives");
        step(0, '0, 1, '0, 0, 0, 0, "R6 idle nested");
        step(0, '0, 0, '0, 0, 1, 0, "R6 endif");
        step(0, '0, 0, '0, 0, 1, 0, "R4 endif outer");
        // R10: priority
        step(0, '0, 1, 64'h1, 1, 1, 0, "R10 if wins");
        step(0, '0, 0, '0, 1, 1, 0, "R10 else wins");
        step(0, '0, 0, '0, 0, 1, 0, "R10 endif");
        step(1, 64'h0000_0000_FFFF_0000, 1, 64'h0, 1, 1, 0, "R10 launch wins");
        // R11: launch clears stack
        step(0, '0, 1, 64'h0000_0000_00FF_0000, 0, 0, 0, "R11 if");
        step(1, 64'h1234_5678_9ABC_DEF0, 0, '0, 0, 0, 0, "R11 launch");
        step(0, '0, 0, '0, 0, 1, 0, "R9 endif empty after launch");
        // R7: no kill when pixel_mode low
        step(1, '0, 0, '0, 0, 0, 0, "R11 launch zero");
        step(0, '0, 1, '1, 0, 0, 0, "R7 if");
        step(0, '0, 0, '0, 0, 1, 0, "R7 no kill non-pixel");
        idle(2, "R7 quiet");
        // R7: no kill at inner level
        step(0, '0, 1, '1, 0, 0, 1, "R7 if outer");
        step(0, '0, 1, '1, 0, 0, 1, "R7 if inner");
        step(0, '0, 0, '0, 0, 1, 1, "R7 inner endif no kill");
        step(0, '0, 0, '0, 0, 1, 1, "R7 outer endif kill");
        idle(3, "R7 export then terminate");
        // R7: no kill when lanes live
        step(1, 64'h8, 0, '0, 0, 0, 1, "R11 launch");
        step(1 - 1, '0, 1, '0, 0, 0, 1, "R7 if");
        step(0, '0, 0, '0, 0, 1, 1, "R7 live no kill");
        idle(2, "R7 quiet");
        // R8: overflow
        step(1, '1, 0, '0, 0, 0, 0, "R11 launch");
        for (int k = 0; k < DEPTH; k++)
            step(0, '0, 1, ~(64'h1 << k), 0, 0, 0, "R8 fill");
        step(0, '0, 1, 64'h0, 0, 0, 0, "R8 overflow");
        idle(1, "R8 sticky");
        for (int k = 0; k < DEPTH; k++)
            step(0, '0, 0, '0, 0, 1, 0, "R8 unwind");
        // R9: underflow on else
        step(0, '0, 0, '0, 1, 0, 0, "R9 else empty");
        idle(2, "R9 sticky");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule